// File: doc/BRIEF.md
# Stimulus-to-Response Latency Monitor

This block watches a stream of executed instruction addresses that trace reconstruction has already decoded. It can take several retired instructions per cycle, one per lane. Two addresses are programmed into it. The first marks a stimulus and the second marks a response. Whenever a valid lane carries the stimulus address, the block notes the current value of a free-running cycle timestamp. Whenever a valid lane carries the response address, the block works out how many cycles have passed since the most recent stimulus. It reports that count as a latency, together with a verdict showing whether the latency is below a programmable limit.

Results leave the block as a one-cycle strobe with the latency and verdict held beside it. The block has no backpressure. A downstream consumer acknowledges each result. If a new result arrives while the previous one is still unacknowledged, a sticky overflow flag is raised.

The three configuration registers can only be written while the monitor is disabled. Disabling the monitor also forgets the last stimulus, clears the pending and overflow state, and stops all event detection. Timestamps are 48 bits wide, and the latency subtraction wraps modulo 2^48.

Top module: `stim_resp_latency_mon`

## Requirements
- R1: After reset, res_valid and res_overflow are 0.
- R2: Configuration writes use cfg_sel 0 for the stimulus address, 1 for the response address and 2 for the latency limit. A write takes effect only if enable is 0 in the cycle of the write, and it is used from the next cycle. A write made while enable is 1 is ignored.
- R3: A stimulus is recognised only when enable is 1 and a lane has its tr_valid bit set while carrying the stimulus address. Lane i occupies tr_addr bits [i*32 +: 32]. A matching address on a lane whose valid bit is 0 has no effect.
- R4: A recognised response that has a recorded stimulus since enable last rose produces res_valid for exactly one cycle. This happens on the clock edge after the response cycle. res_latency then equals the number of cycles between the stimulus cycle and the response cycle.
- R5: A later stimulus replaces an earlier one, so the latency is always measured from the most recent stimulus.
- R6: A response seen when no stimulus has occurred since enable last rose produces no result.
- R7: If a stimulus and a response fall in the same cycle, the stimulus is taken first and the reported latency is 0.
- R8: res_pass is 1 exactly when res_latency is strictly less than the programmed limit. A latency equal to the limit fails.
- R9: A result produced while the previous result is still pending sets res_overflow, which stays set until enable is 0. A res_ack in the same cycle as the new result counts as acknowledging the old one, and then no overflow is raised.
- R10: Several response lanes hitting in one cycle produce a single result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Monitor running; when 0, configuration is writable and state is cleared |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 stimulus address, 1 response address, 2 limit |
| cfg_data | input | 48 | Write data; addresses use the low 32 bits |
| tr_valid | input | 2 | Per-lane retired-instruction valid |
| tr_addr | input | 64 | Per-lane instruction addresses, 32 bits per lane |
| res_ack | input | 1 | Consumer acknowledges the pending result |
| res_valid | output | 1 | One-cycle result strobe |
| res_latency | output | 48 | Cycles from latest stimulus to response |
| res_pass | output | 1 | Latency strictly below limit |
| res_overflow | output | 1 | Sticky: a result arrived while the previous one was unacknowledged |

## Verification
Two pairs of events can collide in one cycle. A stimulus and a response can arrive on different lanes of the same retired group. A fresh result can also coincide with the acknowledgement of the previous result. The bench provokes the first pair directly, by placing the stimulus address on one lane and the response address on the other, and it expects a zero latency. The constrained random phase keeps hitting both collisions by drawing lane addresses from a small pool and driving acknowledgements at random. A bench model predicts, cycle by cycle, the strobe, the latency, the verdict and whether overflow is raised or avoided.

// File: rtl/lmon_pkg.sv
package lmon_pkg;

  parameter int unsigned LM_TS_W = 48;

  typedef logic [LM_TS_W-1:0] ts_t;

  typedef enum logic [1:0] {
    SEL_STIM  = 2'd0,
    SEL_RESP  = 2'd1,
    SEL_LIMIT = 2'd2
  } cfg_sel_e;

  // Elapsed cycles between two timestamps, wrapping modulo 2^LM_TS_W.
  function automatic ts_t lm_elapsed(input ts_t now_ts, input ts_t then_ts);
    return now_ts - then_ts;
  endfunction

  // Verdict: strictly under the limit.
  function automatic logic lm_meets(input ts_t lat, input ts_t limit);
    return lat < limit;
  endfunction

endpackage

// File: rtl/lm_cfg_regs.sv
module lm_cfg_regs
  import lmon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              we,
  input  logic [1:0]        sel,
  input  ts_t               data,
  output logic [ADDR_W-1:0] stim_addr,
  output logic [ADDR_W-1:0] resp_addr,
  output ts_t               limit
);

  logic wr_ok;
  assign wr_ok = we && !enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stim_addr <= '0;
      resp_addr <= '1;
      limit     <= '1;
    end else if (wr_ok) begin
      case (cfg_sel_e'(sel))
        SEL_STIM:  stim_addr <= data[ADDR_W-1:0];
        SEL_RESP:  resp_addr <= data[ADDR_W-1:0];
        SEL_LIMIT: limit     <= data;
        default:   ;
      endcase
    end
  end

  // R2: registers are frozen while the monitor runs
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> ($stable(stim_addr) && $stable(resp_addr) && $stable(limit)));

endmodule

// File: rtl/lm_addr_match.sv
module lm_addr_match #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                    enable,
  input  logic [LANES-1:0]        tr_valid,
  input  logic [LANES*ADDR_W-1:0] tr_addr,
  input  logic [ADDR_W-1:0]       stim_addr,
  input  logic [ADDR_W-1:0]       resp_addr,
  output logic                    stim_hit,
  output logic                    resp_hit
);

  logic [LANES-1:0] stim_lane;
  logic [LANES-1:0] resp_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr    = tr_addr[g*ADDR_W +: ADDR_W];
    assign stim_lane[g] = tr_valid[g] && (lane_addr == stim_addr);
    assign resp_lane[g] = tr_valid[g] && (lane_addr == resp_addr);
  end

  assign stim_hit = enable && (|stim_lane);
  assign resp_hit = enable && (|resp_lane);

endmodule

// File: rtl/lm_timebase.sv
module lm_timebase
  import lmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output ts_t  ts_now
);

  always_ff @(posedge clk) begin
    if (!rst_n) ts_now <= '0;
    else        ts_now <= ts_now + 1'b1;
  end

  // R4: the time base advances by exactly one per cycle
  assert_ts_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ts_now == ts_t'($past(ts_now) + 1'b1));

endmodule

// File: rtl/lm_result.sv
module lm_result
  import lmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic stim_hit,
  input  logic resp_hit,
  input  ts_t  ts_now,
  input  ts_t  limit,
  input  logic res_ack,
  output logic res_valid,
  output ts_t  res_latency,
  output logic res_pass,
  output logic res_overflow
);

  logic seen_q;
  ts_t  stim_ts_q;
  logic pend_q;
  logic produce;
  ts_t  base_ts;
  ts_t  lat_now;

  assign produce = enable && resp_hit && (seen_q || stim_hit);
  assign base_ts = stim_hit ? ts_now : stim_ts_q;
  assign lat_now = lm_elapsed(ts_now, base_ts);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q       <= 1'b0;
      stim_ts_q    <= '0;
      pend_q       <= 1'b0;
      res_valid    <= 1'b0;
      res_latency  <= '0;
      res_pass     <= 1'b0;
      res_overflow <= 1'b0;
    end else if (!enable) begin
      seen_q       <= 1'b0;
      pend_q       <= 1'b0;
      res_valid    <= 1'b0;
      res_overflow <= 1'b0;
    end else begin
      res_valid <= produce;
      if (stim_hit) begin
        seen_q    <= 1'b1;
        stim_ts_q <= ts_now;
      end
      if (produce) begin
        res_latency <= lat_now;
        res_pass    <= lm_meets(lat_now, limit);
      end
      if (produce && pend_q && !res_ack) res_overflow <= 1'b1;
      if (produce)      pend_q <= 1'b1;
      else if (res_ack) pend_q <= 1'b0;
    end
  end

  // R7: a coincident stimulus and response give zero latency
  assert_zero_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(stim_hit && resp_hit)) |-> res_latency == '0);

  // R6: no result without a response and a known stimulus
  assert_needs_stimulus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($past(resp_hit) && $past(seen_q || stim_hit)));

  // R8: verdict agrees with the held limit
  assert_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_pass == (res_latency < limit)));

  // R9: overflow stays set while enabled
  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(res_overflow) && $past(enable)) |-> res_overflow);

  // R1: nothing is reported in the cycle after a disabled cycle
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (!res_valid && !res_overflow));

endmodule

// File: rtl/stim_resp_latency_mon.sv
module stim_resp_latency_mon
  import lmon_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [LM_TS_W-1:0]      cfg_data,
  input  logic [LANES-1:0]        tr_valid,
  input  logic [LANES*ADDR_W-1:0] tr_addr,
  input  logic                    res_ack,
  output logic                    res_valid,
  output logic [LM_TS_W-1:0]      res_latency,
  output logic                    res_pass,
  output logic                    res_overflow
);

  logic [ADDR_W-1:0] stim_addr;
  logic [ADDR_W-1:0] resp_addr;
  ts_t               limit;
  ts_t               ts_now;
  logic              stim_hit;
  logic              resp_hit;

  lm_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .we        (cfg_we),
    .sel       (cfg_sel),
    .data      (cfg_data),
    .stim_addr (stim_addr),
    .resp_addr (resp_addr),
    .limit     (limit)
  );

  lm_addr_match #(.LANES(LANES), .ADDR_W(ADDR_W)) u_match (
    .enable    (enable),
    .tr_valid  (tr_valid),
    .tr_addr   (tr_addr),
    .stim_addr (stim_addr),
    .resp_addr (resp_addr),
    .stim_hit  (stim_hit),
    .resp_hit  (resp_hit)
  );

  lm_timebase u_time (
    .clk    (clk),
    .rst_n  (rst_n),
    .ts_now (ts_now)
  );

  lm_result u_res (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .stim_hit     (stim_hit),
    .resp_hit     (resp_hit),
    .ts_now       (ts_now),
    .limit        (limit),
    .res_ack      (res_ack),
    .res_valid    (res_valid),
    .res_latency  (res_latency),
    .res_pass     (res_pass),
    .res_overflow (res_overflow)
  );

endmodule

// File: tb/stim_resp_latency_mon_bench.sv
module stim_resp_latency_mon_bench;
  localparam int LANES = 2;
  localparam int AW    = 32;
  localparam int TW    = 48;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               enable;
  logic               cfg_we;
  logic [1:0]         cfg_sel;
  logic [TW-1:0]      cfg_data;
  logic [LANES-1:0]   tr_valid;
  logic [LANES*AW-1:0] tr_addr;
  logic               res_ack;
  logic               res_valid;
  logic [TW-1:0]      res_latency;
  logic               res_pass;
  logic               res_overflow;

  int total = 0;
  int bad   = 0;

  logic [AW-1:0] m_s, m_r;
  logic [TW-1:0] m_t;
  logic          m_seen, m_pend, m_ovf, m_valid, m_pass;
  longint        m_cyc, m_stim_cyc, m_lat;

  stim_resp_latency_mon u_stim_resp_latency_mon (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .tr_valid(tr_valid),
    .tr_addr(tr_addr), .res_ack(res_ack), .res_valid(res_valid),
    .res_latency(res_latency), .res_pass(res_pass), .res_overflow(res_overflow)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, predict, check just after the rising edge.
  task automatic cyc(input logic en, input logic v0, input logic [AW-1:0] a0,
                     input logic v1, input logic [AW-1:0] a1, input logic ack,
                     input logic we, input logic [1:0] sel, input logic [TW-1:0] d,
                     input string tag);
    logic sh, rh, prod;
    longint lat;
    @(negedge clk);
    enable = en; tr_valid = {v1, v0}; tr_addr = {a1, a0};
    res_ack = ack; cfg_we = we; cfg_sel = sel; cfg_data = d;
    sh = en && ((v0 && a0 == m_s) || (v1 && a1 == m_s));
    rh = en && ((v0 && a0 == m_r) || (v1 && a1 == m_r));
    if (!en) begin
      m_seen = 0; m_pend = 0; m_ovf = 0; m_valid = 0;
      if (we) begin
        if (sel == 2'd0) m_s = d[AW-1:0];
        else if (sel == 2'd1) m_r = d[AW-1:0];
        else if (sel == 2'd2) m_t = d;
      end
    end else begin
      prod = rh && (m_seen || sh);
      lat  = sh ? 0 : (m_cyc - m_stim_cyc);
      if (sh) begin m_seen = 1; m_stim_cyc = m_cyc; end
      m_valid = prod;
      if (prod) begin m_lat = lat; m_pass = (lat < longint'(m_t)); end
      if (prod && m_pend && !ack) m_ovf = 1;
      if (prod) m_pend = 1; else if (ack) m_pend = 0;
    end
    m_cyc++;
    @(posedge clk); #1;
    chk(res_valid == m_valid, {tag, " valid"}, res_valid, m_valid);
    if (m_valid) begin
      chk(res_latency == m_lat[TW-1:0], {tag, " latency"}, longint'(res_latency), m_lat);
      chk(res_pass == m_pass, {tag, " pass"}, res_pass, m_pass);
    end
    chk(res_overflow == m_ovf, {tag, " overflow"}, res_overflow, m_ovf);
  endtask

  task automatic idle(input logic en, input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(en, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [TW-1:0] d, input logic en, input string tag);
    cyc(en, 0, 0, 0, 0, 0, 1, sel, d, tag);
  endtask

  localparam logic [AW-1:0] S0 = 32'h0000_1000;
  localparam logic [AW-1:0] R0 = 32'h0000_2000;
  localparam logic [AW-1:0] S1 = 32'h0000_3000;

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_s = '0; m_r = '1; m_t = '1;
    m_seen = 0; m_pend = 0; m_ovf = 0; m_valid = 0; m_pass = 0;
    m_cyc = 0; m_stim_cyc = 0; m_lat = 0;
    rst_n = 0; enable = 0; cfg_we = 0; cfg_sel = 0; cfg_data = 0;
    tr_valid = 0; tr_addr = 0; res_ack = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1: reset state
    chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
    chk(res_overflow == 1'b0, "R1 reset overflow", res_overflow, 0);

    // R2: program while disabled
    wr(2'd0, TW'(S0), 0, "R2 cfg");
    wr(2'd1, TW'(R0), 0, "R2 cfg");
    wr(2'd2, 48'd20, 0, "R2 cfg");

    // R6: response with no stimulus yet
    cyc(1, 1, R0, 0, 0, 0, 0, 0, 0, "R6 no stimulus");
    idle(1, 1, "R6 idle");
    // R3: invalid lane carrying stimulus address is ignored
    cyc(1, 0, S0, 0, 0, 0, 0, 0, 0, "R3 invalid lane");
    cyc(1, 1, R0, 0, 0, 0, 0, 0, 0, "R3 after invalid lane");
    // R4: basic latency
    cyc(1, 0, 0, 1, S0, 0, 0, 0, 0, "R4 stim");
    idle(1, 5, "R4 wait");
    cyc(1, 1, R0, 0, 0, 1, 0, 0, 0, "R4 resp");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, 0, "R4 ack");
    // R5: later stimulus replaces earlier
    cyc(1, 1, S0, 0, 0, 0, 0, 0, 0, "R5 stim a");
    idle(1, 4, "R5 wait");
    cyc(1, 1, S0, 0, 0, 0, 0, 0, 0, "R5 stim b");
    idle(1, 2, "R5 wait");
    cyc(1, 0, 0, 1, R0, 1, 0, 0, 0, "R5 resp");
    // R7: same cycle, response on lane 0 and stimulus on lane 1
    cyc(1, 1, R0, 1, S0, 1, 0, 0, 0, "R7 same cycle");
    // R10: both lanes respond in one cycle
    cyc(1, 1, R0, 1, R0, 1, 0, 0, 0, "R10 two lanes");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, 0, "R10 single strobe");
    // R8: limit boundary: 19 passes, 20 fails
    cyc(1, 1, S0, 0, 0, 1, 0, 0, 0, "R8 stim");
    idle(1, 18, "R8 wait");
    cyc(1, 1, R0, 0, 0, 1, 0, 0, 0, "R8 lat19");
    cyc(1, 1, R0, 0, 0, 1, 0, 0, 0, "R8 lat20");
    // R9: ack coinciding with new result avoids overflow, missing ack sets it
    cyc(1, 1, R0, 0, 0, 1, 0, 0, 0, "R9 ack same cycle");
    cyc(1, 1, R0, 0, 0, 0, 0, 0, 0, "R9 unacked");
    cyc(1, 1, R0, 0, 0, 0, 0, 0, 0, "R9 overflow");
    idle(1, 3, "R9 sticky");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 cleared by disable");
    // R2: writes while enabled are ignored
    wr(2'd0, TW'(S1), 1, "R2 ignored write");
    cyc(1, 1, S1, 0, 0, 0, 0, 0, 0, "R2 old stim kept");
    cyc(1, 1, R0, 0, 0, 1, 0, 0, 0, "R2 no result");
    cyc(1, 1, S0, 0, 0, 0, 0, 0, 0, "R2 real stim");
    cyc(1, 1, R0, 0, 0, 1, 0, 0, 0, "R2 result");

    // Random phase (R4, R5, R7, R9 and others)
    for (int i = 0; i < 4000; i++) begin
      logic en, v0, v1, ack, we;
      logic [AW-1:0] a0, a1;
      logic [AW-1:0] pool [4];
      logic [1:0] sel;
      logic [TW-1:0] d;
      pool[0] = S0; pool[1] = R0; pool[2] = S1; pool[3] = 32'h0000_4000;
      en  = ($urandom % 60) != 0;
      v0  = $urandom % 2; v1 = $urandom % 2;
      a0  = pool[$urandom % 4]; a1 = pool[$urandom % 4];
      ack = ($urandom % 3) == 0;
      we  = ($urandom % 8) == 0;
      sel = 2'($urandom % 3);
      d   = (sel == 2'd2) ? TW'($urandom % 40) : TW'(pool[$urandom % 4]);
      cyc(en, v0, a0, v1, a1, ack, we, sel, d, "R4 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule